// File: doc/BRIEF.md
# Receive Queue Statistics Folding Unit

This block keeps receive traffic statistics for 64 queues while holding only 16 pairs of counters. A programmable table assigns each queue to one counter pair. Each pair has a packet counter and a byte counter. Several queues can share a pair, and that pair then sums their traffic. Queue classification and data movement happen elsewhere. The block only sees a per-frame event that gives the queue number and the frame length in bytes.

Software reaches the block through a simple register port with one-cycle read latency. The table is written as 16 words, and each word packs the entries of four consecutive queues. Counters clear when they are read, so software collects the delta since its last read. The byte counters are wider than a data word. A read of the low half captures the upper bits in a holding register, and software reads that register next to rebuild a consistent value.

Top module: `rxqs_stat_top`

## Requirements
- R1: After reset every table entry reads zero and every counter reads zero, so every queue feeds pair 0.
- R2: Table word n (n = 0..15) is at byte address 0x000 + 4n. Queue 4n+j sits in bits 8j+7:8j. All 8 bits of each entry read back as written. Read data appears on `reg_rdata` in the cycle after `reg_rd`, and it is zero otherwise.
- R3: Only the low 4 bits of an entry choose the counter pair. The upper 4 bits have no effect on counting.
- R4: A frame event adds 1 to the packet counter and `ev_len` to the byte counter of the pair chosen for `ev_queue`. No other counter changes.
- R5: When several queues choose the same pair, that pair accumulates the packets and bytes of all of them.
- R6: A table write in the same cycle as a frame event does not affect that event. It applies from the next event onward.
- R7: The packet counter of pair k is at 0x100 + 4k. A read returns its value and clears it.
- R8: The low 32 bits of the byte counter of pair k are at 0x200 + 8k. A read of that address returns them and clears the whole counter. It also copies the upper 4 bits into a single holding register, which reads at any address 0x204 + 8k.
- R9: A frame event that hits a counter in the same cycle as that counter's clearing read is kept. The counter then holds exactly that event's increment.
- R10: Packet counters (32 bits) and byte counters (36 bits) saturate at all ones and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Frame event strobe |
| ev_queue | input | 6 | Receive queue of the frame |
| ev_len | input | 16 | Frame length in bytes |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |

## Verification
Frames are sent first with the reset table, which shows that all queues fold onto pair 0. They are then sent through entries whose upper bits are set, which shows whether those bits leak into the pair choice. Several queues are then aimed at one pair, which separates correct accumulation from a last-writer-wins update. A table write and an event in the same cycle, and a clearing read in the same cycle as an event, show the ordering at the edge. A long run of maximum-length frames pushes a byte counter past 32 bits to test the split read. A second instance with narrow counters is driven into saturation.

// File: rtl/rxqs_pkg.sv
package rxqs_pkg;

   typedef enum logic [1:0] {
      RG_MAP  = 2'd0,
      RG_PKT  = 2'd1,
      RG_BYTE = 2'd2,
      RG_NONE = 2'd3
   } rxqs_region_e;

   typedef struct packed {
      rxqs_region_e region;
      logic [5:0]   widx;
   } rxqs_dec_t;

   localparam int unsigned RXQS_WORD_W = 32;

endpackage

// File: rtl/rxqs_addr_dec.sv
module rxqs_addr_dec
   import rxqs_pkg::*;
#(
   parameter int unsigned ADDR_W = 10
) (
   input  logic [ADDR_W-1:0] addr,
   output rxqs_dec_t         dec
);

   logic upper_zero;

   generate
      if (ADDR_W > 10) begin : g_upper
         assign upper_zero = (addr[ADDR_W-1:10] == '0);
      end else begin : g_no_upper
         assign upper_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      dec.region = upper_zero ? rxqs_region_e'(addr[9:8]) : RG_NONE;
      dec.widx   = addr[7:2];
   end

   logic unused_low;
   assign unused_low = ^addr[1:0];

endmodule

// File: rtl/rxqs_map_file.sv
module rxqs_map_file
   import rxqs_pkg::*;
#(
   parameter int unsigned NUM_QUEUES = 64,
   parameter int unsigned ENTRY_W    = 8,
   parameter int unsigned SEL_W      = 4,
   localparam int unsigned EPW       = RXQS_WORD_W / ENTRY_W,
   localparam int unsigned NUM_WORDS = NUM_QUEUES / EPW,
   localparam int unsigned MI_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
   localparam int unsigned Q_W       = $clog2(NUM_QUEUES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [MI_W-1:0]        wr_idx,
   input  logic [RXQS_WORD_W-1:0] wr_data,
   input  logic [MI_W-1:0]        rd_idx,
   output logic [RXQS_WORD_W-1:0] rd_word,
   input  logic [Q_W-1:0]         lookup_q,
   output logic [SEL_W-1:0]       lookup_sel
);

   logic [ENTRY_W-1:0] ent [NUM_QUEUES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_QUEUES; i++) ent[i] <= '0;
      end else if (wr_en) begin
         for (int j = 0; j < EPW; j++)
            ent[int'(wr_idx) * EPW + j] <= wr_data[j*ENTRY_W +: ENTRY_W];
      end
   end

   always_comb begin
      rd_word = '0;
      for (int j = 0; j < EPW; j++)
         rd_word[j*ENTRY_W +: ENTRY_W] = ent[int'(rd_idx) * EPW + j];
   end

   logic [ENTRY_W-1:0] hit_ent;
   assign hit_ent    = ent[lookup_q];
   assign lookup_sel = hit_ent[SEL_W-1:0];

endmodule

// File: rtl/rxqs_sat_counter.sv
module rxqs_sat_counter #(
   parameter int unsigned W     = 32,
   parameter int unsigned INC_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc_en,
   input  logic [INC_W-1:0] inc_val,
   output logic [W-1:0]     cnt
);

   logic [W-1:0] base;
   logic [W:0]   sum;
   logic [W-1:0] nxt;

   always_comb begin
      base = clr ? '0 : cnt;
      sum  = {1'b0, base} + (W+1)'(inc_en ? inc_val : '0);
      nxt  = sum[W] ? '1 : sum[W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
   end

endmodule

// File: rtl/rxqs_stat_top.sv
module rxqs_stat_top
   import rxqs_pkg::*;
#(
   parameter int unsigned NUM_QUEUES = 64,
   parameter int unsigned NUM_PAIRS  = 16,
   parameter int unsigned ENTRY_W    = 8,
   parameter int unsigned PKT_W      = 32,
   parameter int unsigned BYTE_W     = 36,
   parameter int unsigned LEN_W      = 16,
   parameter int unsigned ADDR_W     = 10,
   localparam int unsigned Q_W       = $clog2(NUM_QUEUES),
   localparam int unsigned SEL_W     = $clog2(NUM_PAIRS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic [Q_W-1:0]    ev_queue,
   input  logic [LEN_W-1:0]  ev_len,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata
);

   localparam int unsigned EPW       = RXQS_WORD_W / ENTRY_W;
   localparam int unsigned NUM_WORDS = NUM_QUEUES / EPW;
   localparam int unsigned MI_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam int unsigned HI_W      = (BYTE_W > 32) ? BYTE_W - 32 : 1;
   localparam logic [5:0]  NW6       = 6'(NUM_WORDS);
   localparam logic [5:0]  NP6       = 6'(NUM_PAIRS);

   // elaboration-time parameter checks
   generate
      if (RXQS_WORD_W % ENTRY_W != 0) begin : g_err_entry
         $error("ENTRY_W must divide the word width");
      end
      if (NUM_QUEUES % EPW != 0 || NUM_WORDS > 64) begin : g_err_words
         $error("NUM_QUEUES must fill at most 64 whole map words");
      end
      if (NUM_PAIRS != (1 << SEL_W) || NUM_PAIRS > 32 || SEL_W > ENTRY_W) begin : g_err_pairs
         $error("NUM_PAIRS must be a power of two, at most 32, selectable by an entry");
      end
      if (PKT_W > 32 || BYTE_W > 64 || BYTE_W < LEN_W) begin : g_err_widths
         $error("counter widths out of range");
      end
      if (ADDR_W < 10) begin : g_err_addr
         $error("ADDR_W must be at least 10");
      end
   endgenerate

   rxqs_dec_t dec;

   rxqs_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
      .addr (reg_addr),
      .dec  (dec)
   );

   logic              map_wr;
   logic [SEL_W-1:0]  ev_sel;
   logic [31:0]       map_word;

   assign map_wr = reg_wr && (dec.region == RG_MAP) && (dec.widx < NW6);

   rxqs_map_file #(
      .NUM_QUEUES (NUM_QUEUES),
      .ENTRY_W    (ENTRY_W),
      .SEL_W      (SEL_W)
   ) map_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (map_wr),
      .wr_idx     (dec.widx[MI_W-1:0]),
      .wr_data    (reg_wdata),
      .rd_idx     (dec.widx[MI_W-1:0]),
      .rd_word    (map_word),
      .lookup_q   (ev_queue),
      .lookup_sel (ev_sel)
   );

   logic [SEL_W-1:0] byte_idx;
   logic             byte_hi;
   logic             rd_pkt;
   logic             rd_byte_lo;
   logic             rd_byte_hi;

   assign byte_idx   = dec.widx[SEL_W:1];
   assign byte_hi    = dec.widx[0];
   assign rd_pkt     = reg_rd && (dec.region == RG_PKT) && (dec.widx < NP6);
   assign rd_byte_lo = reg_rd && (dec.region == RG_BYTE) && !byte_hi
                       && ({1'b0, dec.widx[5:1]} < NP6);
   assign rd_byte_hi = reg_rd && (dec.region == RG_BYTE) && byte_hi
                       && ({1'b0, dec.widx[5:1]} < NP6);

   logic [PKT_W-1:0]  pkt_cnt  [NUM_PAIRS];
   logic [BYTE_W-1:0] byte_cnt [NUM_PAIRS];
   logic [31:0]       byte_lo  [NUM_PAIRS];
   logic [HI_W-1:0]   byte_up  [NUM_PAIRS];

   generate
      for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
         logic hit;
         logic pkt_clr;
         logic byte_clr;

         assign hit      = ev_valid && (ev_sel == SEL_W'(k));
         assign pkt_clr  = rd_pkt && (dec.widx[SEL_W-1:0] == SEL_W'(k));
         assign byte_clr = rd_byte_lo && (byte_idx == SEL_W'(k));

         rxqs_sat_counter #(.W(PKT_W), .INC_W(1)) pkt_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (pkt_clr),
            .inc_en  (hit),
            .inc_val (1'b1),
            .cnt     (pkt_cnt[k])
         );

         rxqs_sat_counter #(.W(BYTE_W), .INC_W(LEN_W)) byte_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (byte_clr),
            .inc_en  (hit),
            .inc_val (ev_len),
            .cnt     (byte_cnt[k])
         );

         if (BYTE_W > 32) begin : g_split
            assign byte_lo[k] = byte_cnt[k][31:0];
            assign byte_up[k] = byte_cnt[k][BYTE_W-1:32];
         end else begin : g_narrow
            assign byte_lo[k] = 32'(byte_cnt[k]);
            assign byte_up[k] = '0;
         end
      end
   endgenerate

   logic [HI_W-1:0] up_hold;
   logic [31:0]     rd_mux;

   always_comb begin
      rd_mux = '0;
      unique case (dec.region)
         RG_MAP:  if (dec.widx < NW6) rd_mux = map_word;
         RG_PKT:  if (rd_pkt) rd_mux = 32'(pkt_cnt[dec.widx[SEL_W-1:0]]);
         RG_BYTE: begin
            if (rd_byte_lo)      rd_mux = byte_lo[byte_idx];
            else if (rd_byte_hi) rd_mux = 32'(up_hold);
         end
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
         up_hold   <= '0;
      end else begin
         reg_rdata <= reg_rd ? rd_mux : '0;
         if (rd_byte_lo) up_hold <= byte_up[byte_idx];
      end
   end

endmodule

// File: rtl/rxqs_cnt_chk.sv
module rxqs_cnt_chk #(
   parameter int unsigned W     = 32,
   parameter int unsigned INC_W = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             inc_en,
   input logic [INC_W-1:0] inc_val,
   input logic [W-1:0]     cnt
);

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> cnt >= $past(cnt)); // R10

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '1 && !clr) |=> cnt == '1); // R10

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc_en) |=> $stable(cnt)); // R4

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !inc_en) |=> cnt == '0); // R7

   AST_CLR_KEEPS_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && inc_en) |=> cnt == W'($past(inc_val))); // R9

endmodule

bind rxqs_sat_counter rxqs_cnt_chk #(.W(W), .INC_W(INC_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .clr     (clr),
   .inc_en  (inc_en),
   .inc_val (inc_val),
   .cnt     (cnt)
);

// File: tb/rxqs_stat_top_tb.sv
`timescale 1ns/1ps
module rxqs_stat_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic        s_ev_valid = 1'b0;
   logic [5:0]  ev_queue = '0;
   logic [15:0] ev_len = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [9:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] s_rdata;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rxqs_stat_top dut_i (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_queue(ev_queue),
      .ev_len(ev_len), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   rxqs_stat_top #(.PKT_W(4), .BYTE_W(8), .LEN_W(8)) sat_i (
      .clk(clk), .rst_n(rst_n), .ev_valid(s_ev_valid), .ev_queue(ev_queue),
      .ev_len(ev_len[7:0]), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(s_rdata)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   // one bus cycle with optional write, read and event; sampled at the next falling edge
   task automatic op(input logic wr, input logic rd, input logic [9:0] addr,
                     input logic [31:0] wd, input logic ev, input logic [5:0] q,
                     input logic [15:0] len, output logic [31:0] d, output logic [31:0] sd);
      @(negedge clk);
      reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = wd;
      ev_valid = ev; ev_queue = q; ev_len = len;
      @(negedge clk);
      d = reg_rdata; sd = s_rdata;
      reg_wr = 1'b0; reg_rd = 1'b0; ev_valid = 1'b0;
   endtask

   task automatic wr_map(input int n, input logic [31:0] v);
      logic [31:0] d, sd;
      op(1'b1, 1'b0, 10'(4*n), v, 1'b0, '0, '0, d, sd);
   endtask

   task automatic rd_reg(input logic [9:0] a, output logic [31:0] d);
      logic [31:0] sd;
      op(1'b0, 1'b1, a, '0, 1'b0, '0, '0, d, sd);
   endtask

   task automatic frame(input logic [5:0] q, input logic [15:0] len);
      logic [31:0] d, sd;
      op(1'b0, 1'b0, '0, '0, 1'b1, q, len, d, sd);
   endtask

   function automatic logic [9:0] pkt_a(input int k);  return 10'(32'h100 + 4*k); endfunction
   function automatic logic [9:0] blo_a(input int k);  return 10'(32'h200 + 8*k); endfunction
   function automatic logic [9:0] bhi_a(input int k);  return 10'(32'h204 + 8*k); endfunction

   task automatic t_reset;
      logic [31:0] d;
      logic [31:0] acc = '0;
      for (int n = 0; n < 16; n++) begin rd_reg(10'(4*n), d); acc |= d; end
      chk("R1", "map words after reset", acc, 32'h0);
      acc = '0;
      for (int k = 0; k < 16; k++) begin rd_reg(pkt_a(k), d); acc |= d; end
      chk("R1", "packet counters after reset", acc, 32'h0);
      chk("R2", "rdata idle after read", reg_rdata, 32'h0);
   endtask

   task automatic t_default_pair;
      logic [31:0] d;
      frame(6'd40, 16'd100);
      frame(6'd63, 16'd50);
      rd_reg(pkt_a(0), d);  chk("R1", "pair0 packets with reset map", d, 32'd2);
      rd_reg(blo_a(0), d);  chk("R4", "pair0 bytes with reset map", d, 32'd150);
   endtask

   task automatic t_map_rw;
      logic [31:0] d;
      wr_map(3, 32'hA513F207);
      rd_reg(10'h00C, d);
      chk("R2", "word 3 readback", d, 32'hA513F207);
      rd_reg(10'h008, d);
      chk("R2", "word 2 untouched", d, 32'h0);
   endtask

   task automatic t_select;
      logic [31:0] d;
      // queue 13 entry 0xF2 -> pair 2, queue 12 entry 0x07 -> pair 7
      frame(6'd13, 16'd64);
      frame(6'd12, 16'd1000);
      rd_reg(pkt_a(2), d);  chk("R3", "entry 0xF2 counts in pair 2", d, 32'd1);
      rd_reg(blo_a(2), d);  chk("R3", "pair 2 bytes", d, 32'd64);
      rd_reg(pkt_a(15), d); chk("R3", "upper bits do not pick pair 15", d, 32'd0);
      rd_reg(blo_a(7), d);  chk("R4", "pair 7 bytes", d, 32'd1000);
      rd_reg(pkt_a(0), d);  chk("R4", "pair 0 untouched", d, 32'd0);
   endtask

   task automatic t_many;
      logic [31:0] d;
      wr_map(10, 32'h09090909);   // queues 40..43 -> pair 9
      frame(6'd40, 16'd10);
      frame(6'd41, 16'd20);
      frame(6'd43, 16'd30);
      rd_reg(pkt_a(9), d);  chk("R5", "pair 9 packets from three queues", d, 32'd3);
      rd_reg(blo_a(9), d);  chk("R5", "pair 9 bytes from three queues", d, 32'd60);
      rd_reg(pkt_a(9), d);  chk("R7", "packet counter cleared by read", d, 32'd0);
      rd_reg(blo_a(9), d);  chk("R8", "byte counter cleared by read", d, 32'd0);
   endtask

   task automatic t_wr_same;
      logic [31:0] d, sd;
      op(1'b1, 1'b0, 10'h000, 32'h00000004, 1'b1, 6'd0, 16'd5, d, sd);
      frame(6'd0, 16'd7);
      rd_reg(pkt_a(0), d);  chk("R6", "same-cycle event used old entry", d, 32'd1);
      rd_reg(blo_a(0), d);  chk("R6", "old entry bytes", d, 32'd5);
      rd_reg(blo_a(4), d);  chk("R6", "next event used new entry", d, 32'd7);
      rd_reg(pkt_a(4), d);  chk("R6", "new pair packets", d, 32'd1);
   endtask

   task automatic t_coincide;
      logic [31:0] d, sd;
      frame(6'd40, 16'd1);
      frame(6'd40, 16'd1);
      op(1'b0, 1'b1, pkt_a(9), '0, 1'b1, 6'd40, 16'd11, d, sd);
      chk("R7", "read returns pre-clear packets", d, 32'd2);
      rd_reg(pkt_a(9), d);  chk("R9", "coincident packet kept", d, 32'd1);
      op(1'b0, 1'b1, blo_a(9), '0, 1'b1, 6'd41, 16'd11, d, sd);
      chk("R8", "read returns pre-clear bytes", d, 32'd13);
      rd_reg(blo_a(9), d);  chk("R9", "coincident bytes kept", d, 32'd11);
      rd_reg(pkt_a(9), d);  chk("R9", "second coincident packet", d, 32'd1);
   endtask

   task automatic t_wide;
      logic [31:0] d;
      wr_map(15, 32'h0E0E0E0E);   // queues 60..63 -> pair 14
      @(negedge clk);
      ev_valid = 1'b1; ev_queue = 6'd60; ev_len = 16'hFFFF;
      repeat (65538) @(negedge clk);
      ev_valid = 1'b0;
      rd_reg(blo_a(14), d); chk("R8", "low word past 2^32", d, 32'd65534);
      rd_reg(bhi_a(14), d); chk("R8", "held upper bits", d, 32'd1);
      rd_reg(pkt_a(14), d); chk("R4", "long run packet count", d, 32'd65538);
      rd_reg(blo_a(14), d); chk("R8", "low word after clear", d, 32'd0);
      rd_reg(bhi_a(14), d); chk("R8", "upper bits after clear", d, 32'd0);
   endtask

   task automatic t_sat;
      logic [31:0] d, sd;
      @(negedge clk);
      s_ev_valid = 1'b1; ev_queue = 6'd5; ev_len = 16'd200;
      repeat (20) @(negedge clk);
      s_ev_valid = 1'b0;
      op(1'b0, 1'b1, pkt_a(0), '0, 1'b0, '0, '0, d, sd);
      chk("R10", "narrow packet counter saturates", sd, 32'd15);
      chk("R4", "main instance pair 0 unaffected", d, 32'd0);
      op(1'b0, 1'b1, blo_a(0), '0, 1'b0, '0, '0, d, sd);
      chk("R10", "narrow byte counter saturates", sd, 32'd255);
      op(1'b0, 1'b1, pkt_a(0), '0, 1'b0, '0, '0, d, sd);
      chk("R7", "saturated counter cleared", sd, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_default_pair();
      t_map_rw();
      t_select();
      t_many();
      t_wr_same();
      t_coincide();
      t_wide();
      t_sat();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule